// File: doc/BRIEF.md
# Dual-Frequency Numerically Controlled Oscillator

This block is a digital sine source. A host loads two 32-bit tuning words and four 12-bit phase offsets through a simple write strobe. On every active clock the block adds the tuning word chosen by `freq_sel` to a 32-bit phase accumulator. It then adds the offset chosen by `phase_sel` to the top 12 accumulator bits. The resulting 12-bit phase is turned into a 10-bit offset-binary sine code. The output frequency is the tuning word times the clock rate over 2^32. Switching tuning words never makes the phase jump, which suits frequency-shift keying. Switching offsets gives phase-shift keying in steps of 2π/4096.

Every control path has the same fixed latency. A select change or a register write that the clock samples at edge k shows up in `sample` right after edge k+5. Both select inputs are registered on the clock.

`rst_n` clears only the accumulator and the datapath stages. The loaded words survive a reset. `sleep_n` low freezes all state. The output stream is `sample` qualified by `sample_valid`, and it has no ready input. An oscillator cannot stall without losing its phase relation to the clock, so it applies no back-pressure. The consumer must take `sample` on every clock in which `sample_valid` is high.

Top module: `nco_core`

## Requirements
- R1: The phase accumulator is 32 bits wide and wraps modulo 2^32. On each clock with `rst_n` and `sleep_n` high, it adds the selected tuning word. With tuning word 0x40000000 and a zero offset, the output repeats a four-sample cycle whose phase steps by a quarter turn.
- R2: `freq_sel` = 0 selects tuning word 0 and `freq_sel` = 1 selects tuning word 1. A switch changes only the step size from then on. The accumulator continues from its current value.
- R3: `phase_sel` = {bit1,bit0} selects offset 0 for 00, offset 1 for 01, offset 2 for 10 and offset 3 for 11. The selected offset is added modulo 4096 to accumulator bits [31:20]. One offset LSB is 2π/4096.
- R4: For a 12-bit phase p, `sample` = 512 + round(511·sin(2π·p/4096)), rounded half away from zero. So p=0 gives 512, p=1024 gives 1023, p=2048 gives 512 and p=3072 gives 1.
- R5: A value of `freq_sel` or `phase_sel` sampled at rising edge k first affects `sample` immediately after edge k+5. Through edge k+4, `sample` still reflects the earlier setting.
- R6: A write with `wr_en`=1 stores `wr_data` at the clock edge as follows:
  - `wr_addr` 0 loads word 0 bits [15:0], and 1 loads word 0 bits [31:16].
  - 2 loads word 1 bits [15:0], and 3 loads word 1 bits [31:16].
  - 4 to 7 load offsets 0 to 3 from `wr_data[11:0]`. `wr_data[15:12]` is ignored for these addresses.
  - A written word has the same six-edge latency as a select change.
- R7: While `rst_n` is low, `sample` reads 512 and `sample_valid` reads 0 from the first clock edge on. The accumulator returns to zero. The tuning words and offsets keep their contents, and writes are still accepted during reset.
- R8: While `sleep_n` is low, the accumulator and all pipeline stages hold, so `sample` is stable. Writes are ignored. When `sleep_n` returns high, the sequence resumes from the held phase.
- R9: `sample_valid` equals the value of `sleep_n` sampled at the previous clock edge, and it is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the accumulator and datapath |
| sleep_n | input | 1 | Active-low sleep; low freezes all state and blocks writes |
| wr_en | input | 1 | Register write strobe, sampled on the clock |
| wr_addr | input | 3 | Destination register for a write |
| wr_data | input | 16 | Write data |
| freq_sel | input | 1 | Tuning word select |
| phase_sel | input | 2 | Phase offset select |
| sample | output | 10 | Offset-binary sine code |
| sample_valid | output | 1 | High when `sample` is a live sample |

## Verification
A wrong accumulator value or a wrong step never heals. It shows as a constant phase error in every later sample, five edges after the fault. A mis-decoded select or write address gives a wrong but steady code within six edges of the change. An extra or missing pipeline stage moves every transition by one sample relative to a reference delayed by exactly six edges, so the first switch after reset exposes it. A bad sine table entry or bad quadrant folding shows only at the phases that use it, so the stimulus sweeps all four quadrants and the peaks.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W   = 32;
  localparam int PH_W    = 12;
  localparam int OUT_W   = 10;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int N_FREQ  = 2;
  localparam int N_OFS   = 4;
  localparam real NCO_PI = 3.14159265358979323846;
endpackage

// File: rtl/nco_regfile.sv
module nco_regfile
  import nco_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int PW = PH_W,
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [AW-1:0]   freq_word [N_FREQ],
  output logic [PW-1:0]   ofs_word  [N_OFS]
);
  localparam int HALVES = AW / DW;

  logic [DW-1:0] fhalf [N_FREQ][HALVES];

  // Address bit 2 picks the bank, bit 1 the word, bit 0 the half.
  always_ff @(posedge clk) begin
    if (ce && wr_en) begin
      if (!wr_addr[2])
        fhalf[wr_addr[1]][wr_addr[0]] <= wr_data;
      else
        ofs_word[wr_addr[1:0]] <= wr_data[PW-1:0];
    end
  end

  for (genvar w = 0; w < N_FREQ; w++) begin : g_word
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign freq_word[w][h*DW +: DW] = fhalf[w][h];
    end
  end

  // R6: an offset write lands in the addressed slot at that edge
  a_r6_ofs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && wr_en && wr_addr[2]) |=>
      (ofs_word[$past(wr_addr[1:0])] == $past(wr_data[PW-1:0])));

  // R8: writes are blocked during sleep
  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && wr_en && wr_addr == 3'd4) |=> $stable(ofs_word[0]));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int PW = PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          freq_sel,
  input  logic [1:0]    phase_sel,
  input  logic [AW-1:0] freq_word [N_FREQ],
  input  logic [PW-1:0] ofs_word  [N_OFS],
  output logic [PW-1:0] phase
);
  // Stage 1: registered selects
  logic       fsel_q;
  logic [1:0] psel_q;
  // Stage 2: accumulator and aligned offset
  logic [AW-1:0] acc;
  logic [PW-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsel_q <= 1'b0;
      psel_q <= 2'b00;
    end else if (ce) begin
      fsel_q <= freq_sel;
      psel_q <= phase_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      ofs_q <= '0;
    end else if (ce) begin
      acc   <= acc + freq_word[fsel_q];
      ofs_q <= ofs_word[psel_q];
    end
  end

  // Stage 3: truncated phase plus offset, modulo 2^PW
  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= '0;
    else if (ce)
      phase <= acc[AW-1 -: PW] + ofs_q;
  end

  // R8: the accumulator holds while asleep
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(acc));

  // R8: the phase stage holds while asleep
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(phase));

  // R5: the select registers change only when they sample
  a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(fsel_q) && $stable(psel_q)));
endmodule

// File: rtl/nco_sine_map.sv
module nco_sine_map
  import nco_pkg::*;
#(
  parameter int PW = PH_W,
  parameter int OW = OUT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [PW-1:0] phase,
  output logic [OW-1:0] sample
);
  localparam int QW    = PW - 2;
  localparam int QN    = 1 << QW;
  localparam int MAG_W = OW - 1;
  localparam int MID   = 1 << (OW - 1);
  localparam int AMP   = MID - 1;

  function automatic logic [MAG_W-1:0] qmag(input int i);
    real r;
    r = real'(AMP) * $sin(2.0 * NCO_PI * real'(i) / real'(1 << PW));
    return MAG_W'($rtoi(r + 0.5));
  endfunction

  // Quarter-wave magnitude table, endpoints included
  logic [MAG_W-1:0] qtab [QN+1];
  for (genvar g = 0; g <= QN; g++) begin : g_tab
    localparam logic [MAG_W-1:0] V = qmag(g);
    assign qtab[g] = V;
  end

  // Stage 4: quadrant fold
  logic [1:0]    quad;
  logic [QW-1:0] low;
  logic [QW:0]   idx_d;
  logic [QW:0]   idx_q;
  logic          neg_q;

  always_comb begin
    quad  = phase[PW-1 -: 2];
    low   = phase[QW-1:0];
    if (quad[0])
      idx_d = (QW+1)'(QN) - {1'b0, low};
    else
      idx_d = {1'b0, low};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      neg_q <= 1'b0;
    end else if (ce) begin
      idx_q <= idx_d;
      neg_q <= quad[1];
    end
  end

  // Stage 5: table read
  logic [MAG_W-1:0] mag_q;
  logic             neg2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_q  <= '0;
      neg2_q <= 1'b0;
    end else if (ce) begin
      mag_q  <= qtab[idx_q];
      neg2_q <= neg_q;
    end
  end

  // Stage 6: offset-binary output
  always_ff @(posedge clk) begin
    if (!rst_n)
      sample <= OW'(MID);
    else if (ce)
      sample <= neg2_q ? (OW'(MID) - {1'b0, mag_q}) : (OW'(MID) + {1'b0, mag_q});
  end

  // R4: a quarter-turn index reads full amplitude
  a_r4_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && idx_q == (QW+1)'(QN)) |=> (mag_q == MAG_W'(AMP)));

  // R4: a zero index reads zero magnitude
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && idx_q == '0) |=> (mag_q == '0));

  // R4: code zero never appears in the output
  a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    sample != '0);

  // R8: the output is frozen while asleep
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(sample));
endmodule

// File: rtl/nco_core.sv
module nco_core
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              freq_sel,
  input  logic [1:0]        phase_sel,
  output logic [OUT_W-1:0]  sample,
  output logic              sample_valid
);
  logic [ACC_W-1:0] freq_word [N_FREQ];
  logic [PH_W-1:0]  ofs_word  [N_OFS];
  logic [PH_W-1:0]  phase;

  nco_regfile #(.AW(ACC_W), .PW(PH_W), .DW(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (sleep_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .freq_word (freq_word),
    .ofs_word  (ofs_word)
  );

  nco_phase_acc #(.AW(ACC_W), .PW(PH_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (sleep_n),
    .freq_sel  (freq_sel),
    .phase_sel (phase_sel),
    .freq_word (freq_word),
    .ofs_word  (ofs_word),
    .phase     (phase)
  );

  nco_sine_map #(.PW(PH_W), .OW(OUT_W)) u_sine (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (sleep_n),
    .phase  (phase),
    .sample (sample)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      sample_valid <= 1'b0;
    else
      sample_valid <= sleep_n;
  end

  // R9: valid tracks the sleep input one edge later
  a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sample_valid == $past(sleep_n)));
endmodule

// File: tb/nco_core_test.sv
module nco_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        freq_sel = 1'b0;
  logic [1:0]  phase_sel = 2'b00;
  logic [9:0]  sample;
  logic        sample_valid;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R7";

  nco_core uut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .freq_sel(freq_sel),
    .phase_sel(phase_sel), .sample(sample), .sample_valid(sample_valid)
  );

  always #2 clk = ~clk;

  function automatic int sine_code(input int p);
    real r;
    r = 511.0 * $sin(2.0 * 3.14159265358979323846 * real'(p) / 4096.0);
    if (r >= 0.0) return 512 + $rtoi(r + 0.5);
    else          return 512 - $rtoi(-r + 0.5);
  endfunction

  // Behavioural reference: register contents, accumulator, 4-deep delay queue
  logic [31:0] m_freq [2];
  logic [11:0] m_ofs  [4];
  logic [31:0] m_acc;
  logic        m_fsel;
  logic [1:0]  m_psel;
  int          m_q[$];
  int          exp_sample;
  logic        exp_valid;
  bit          cmp_on = 0;

  task automatic m_write();
    if (wr_en) begin
      case (wr_addr)
        3'd0: m_freq[0][15:0]  = wr_data;
        3'd1: m_freq[0][31:16] = wr_data;
        3'd2: m_freq[1][15:0]  = wr_data;
        3'd3: m_freq[1][31:16] = wr_data;
        default: m_ofs[wr_addr - 3'd4] = wr_data[11:0];
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      if (sleep_n) m_write();
      m_acc = '0; m_fsel = 1'b0; m_psel = 2'b00;
      m_q = {512, 512, 512, 512};
      exp_sample = 512;
      exp_valid = 1'b0;
    end else begin
      if (sleep_n) begin
        logic [11:0] ph;
        m_acc = m_acc + m_freq[m_fsel];
        ph = m_acc[31:20] + m_ofs[m_psel];
        m_q.push_back(sine_code(int'(ph)));
        exp_sample = m_q.pop_front();
        m_write();
        m_fsel = freq_sel;
        m_psel = phase_sel;
      end
      exp_valid = sleep_n;
    end
    cmp_on = 1;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_checks++;
      if (int'(sample) != exp_sample || sample_valid !== exp_valid) begin
        n_fail++;
        $display("FAIL %s model: sample=%0d valid=%0b expected sample=%0d valid=%0b",
                 cur_req, sample, sample_valid, exp_sample, exp_valid);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_freq(input int w, input logic [31:0] v);
    wr(2*w, int'(v[15:0]));
    wr(2*w + 1, int'(v[31:16]));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int s [4];
    int held;
    logic [15:0] lfsr;
    int exp_ofs [4];

    exp_ofs = '{512, 1023, 151, 1};
    @(negedge clk);
    // R7: reset state; writes accepted in reset
    for (int a = 0; a < 8; a++) wr(a, 0);
    check("R7 reset sample", int'(sample), 512);
    check("R9 reset valid", int'(sample_valid), 0);

    // R6: offsets written with junk in bits 15:12
    wr(4, 16'h5000);
    wr(5, 16'hF400);
    wr(6, 16'hAA00);
    wr(7, 16'h0C00);
    rst_n = 1'b1;
    cur_req = "R3";
    idle(8);
    check("R3 offset 0", int'(sample), 512);
    check("R9 valid after reset", int'(sample_valid), 1);

    // R5/R3: each select value, exact six-edge latency
    for (int p = 1; p < 4; p++) begin
      cur_req = "R5";
      phase_sel = 2'(p);
      for (int i = 1; i <= 6; i++) begin
        @(negedge clk);
        if (i == 5) check("R5 before latency", int'(sample), exp_ofs[p-1]);
        if (i == 6) check("R3 offset select", int'(sample), exp_ofs[p]);
      end
    end

    // R7: reset mid-run keeps registers, clears accumulator
    cur_req = "R7";
    phase_sel = 2'b01;
    wr_freq(0, 32'h00123456);
    idle(20);
    wr_freq(0, 32'h0);
    rst_n = 1'b0;
    idle(3);
    check("R7 midscale in reset", int'(sample), 512);
    check("R9 valid low in reset", int'(sample_valid), 0);
    rst_n = 1'b1;
    idle(8);
    check("R7 registers retained", int'(sample), 1023);

    // R1: quarter-turn step gives a four-sample cycle
    cur_req = "R1";
    phase_sel = 2'b00;
    wr(4, 0);
    wr_freq(0, 32'h40000000);
    idle(10);
    for (int i = 0; i < 4; i++) begin s[i] = int'(sample); @(negedge clk); end
    check("R1 half-turn symmetry a", s[0] + s[2], 1024);
    check("R1 half-turn symmetry b", s[1] + s[3], 1024);
    check("R4 peak present", (s[0] == 1023 || s[1] == 1023 || s[2] == 1023 || s[3] == 1023) ? 1 : 0, 1);
    // R1: wrap with a near-full-scale word, written half by half mid-run
    wr_freq(0, 32'hFFF3A001);
    idle(300);

    // R2: two words, toggling select, phase continuous
    cur_req = "R2";
    wr_freq(0, 32'h051EB852);
    wr_freq(1, 32'h1FBE76C9);
    for (int i = 0; i < 400; i++) begin
      freq_sel = ((i / 7) % 2 == 1);
      @(negedge clk);
    end

    // R8: sleep freezes output and ignores writes
    cur_req = "R8";
    sleep_n = 1'b0;
    @(negedge clk);
    held = int'(sample);
    wr_freq(freq_sel, 32'h20000000);
    wr(4, 16'h0800);
    for (int i = 0; i < 6; i++) begin
      check("R8 output held", int'(sample), held);
      check("R9 valid low asleep", int'(sample_valid), 0);
      @(negedge clk);
    end
    sleep_n = 1'b1;
    idle(40);

    // R4: pseudo-random selects and writes across all quadrants
    cur_req = "R4";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      freq_sel = lfsr[0];
      phase_sel = lfsr[2:1];
      if (lfsr[7:4] == 4'h3) wr(4 + int'(lfsr[9:8]), int'(lfsr));
      else if (lfsr[7:4] == 4'h9) wr(int'(lfsr[11:10]), int'(lfsr ^ 16'h3C5A));
      else if (lfsr[7:4] == 4'hE) begin
        sleep_n = 1'b0; @(negedge clk); sleep_n = 1'b1;
      end else @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule